// File: doc/BRIEF.md
# HyperBus Single-Transaction Sequencer

This block runs exactly one HyperBus-style transaction each time it is asked. A host presents a request on a flat set of inputs: direction, address space, burst kind, a byte address, a transfer size and up to 64 bits of write data. It then pulses `start`. The engine packs a 48-bit command-address header and drives it onto an 8-bit double-data-rate bus. For reads it inserts a fixed latency gap, then moves the data words and returns read data in a holding register.

The device side is modelled at the cycle level. Each controller clock carries two bus bytes on a 16-bit parallel port: bits [15:8] are the byte on the rising edge and bits [7:0] the byte on the falling edge. Chip select, clock enable and output enable frame the transaction. The `done` output is the only status. It is high whenever the engine is idle and the previous transaction has completed, and a host waits for it before it issues the next request.

Top module: `hbus_xact_engine`

## Requirements
- R1: While reset is held and right after it, `done` is 1, `bus_cs_n` is 1, `bus_ck_en` is 0, `bus_oe` is 0 and `rdata` is 0.
- R2: Header bit 47 is 1 for a read and 0 for a write. Bit 46 is 1 for register space and 0 for memory space. Bit 45 is 1 for a linear burst and 0 for a wrapped burst.
- R3: The word address is the byte address shifted right by one, 24 bits wide. Header bits [44:16] hold word-address bits [23:3], zero-extended. Bits [2:0] hold word-address bits [2:0]. Bits [15:3] are zero. The header goes out over three cycles in the order [47:32], [31:16], [15:0], with `bus_oe` high.
- R4: `req_size` selects the data length: 2'b00 is one 16-bit word, 2'b01 is two words, and 2'b10 and 2'b11 are four words.
- R5: A read has exactly `DUMMY_CYC` cycles (default 14) between the header and the data, with `bus_oe` low and chip select held. A write has no such gap.
- R6: Write word i is `req_wdata[16i+15:16i]`, and word 0 goes on the bus first, in the cycle after the last header cycle.
- R7: In register space each 16-bit word is byte-swapped between the host side and the bus, in both directions. In memory space words pass through unchanged.
- R8: Read word k, counted in arrival order, lands in `rdata[16k+15:16k]`, sampled from `bus_din` at the clock edge that ends its bus cycle. Words beyond the transfer size read as 0.
- R9: `done` is 0 from the cycle after an accepted start until the transaction ends. It rises on the same edge that captures the last word. `bus_cs_n` is low, and `bus_ck_en` high, for exactly the header, gap and data cycles.
- R10: Chip select returns high for at least one cycle between two transactions, even when `start` is held high throughout.
- R11: A `start` that arrives while `done` is 0 is ignored. It neither alters the running transaction nor launches another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only when idle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_reg_space | input | 1 | 1 = register space, 0 = memory space |
| req_linear | input | 1 | 1 = linear burst, 0 = wrapped burst |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Transfer size code |
| req_wdata | input | 64 | Write data, word 0 in the low bits |
| done | output | 1 | Idle and previous transaction finished |
| rdata | output | 64 | Captured read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ck_en | output | 1 | Bus clock enable |
| bus_oe | output | 1 | Controller drives the data bus |
| bus_dout | output | 16 | Rising byte [15:8], falling byte [7:0] |
| bus_din | input | 16 | Read data from the device, same byte layout |

## Verification
The hardest situation to reach from the ports is a strobe that coincides with the single idle cycle between transactions while a request is still in flight. A host that polls `done` never produces it. The stimulus holds `start` high across a whole transaction so that a second one launches from that one idle cycle, and the monitor measures the chip-select gap. Separately, extra strobes with altered fields are injected in mid-transaction. The expectation queue then exposes any header corruption or any unrequested transaction.

// File: rtl/hbx_pkg.sv
package hbx_pkg;
  localparam int WORD_W    = 16;
  localparam int MAX_WORDS = 4;
  localparam int HDR_W     = 48;
  localparam int HDR_BEATS = HDR_W / WORD_W;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_WAIT, ST_XFER} hbx_state_e;

  // index of the final data word for a size code
  function automatic logic [1:0] size_to_last(input logic [1:0] sz);
    case (sz)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/hbx_ca_build.sv
module hbx_ca_build #(
  parameter int ADDR_W = 25
) (
  input  logic                     rd,
  input  logic                     reg_space,
  input  logic                     linear,
  input  logic [ADDR_W-1:0]        byte_addr,
  output logic [hbx_pkg::HDR_W-1:0] hdr
);
  localparam int WA_W = ADDR_W - 1;
  localparam int HI_W = 29;

  logic [WA_W-1:0] waddr;
  logic [HI_W-1:0] upper;

  assign waddr = WA_W'(byte_addr >> 1);
  assign upper = HI_W'(waddr >> 3);

  always_comb begin
    hdr         = '0;
    hdr[47]     = rd;
    hdr[46]     = reg_space;
    hdr[45]     = linear;
    hdr[44:16]  = upper;
    hdr[2:0]    = waddr[2:0];
  end
endmodule

// File: rtl/hbx_swap.sv
module hbx_swap #(
  parameter int NW = 4
) (
  input  logic                        en,
  input  logic [hbx_pkg::WORD_W*NW-1:0] din,
  output logic [hbx_pkg::WORD_W*NW-1:0] dout
);
  localparam int W = hbx_pkg::WORD_W;

  for (genvar i = 0; i < NW; i++) begin : g_word
    assign dout[i*W +: W] = en ? {din[i*W +: 8], din[i*W+8 +: 8]} : din[i*W +: W];
  end
endmodule

// File: rtl/hbx_seq.sv
module hbx_seq #(
  parameter int DUMMY_CYC = 14,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rd_q,
  input  logic [1:0]       last_idx,
  output logic             accept,
  output logic             shift_en,
  output logic             cap_en,
  output logic [CNT_W-1:0] cnt,
  output logic             done,
  output logic             cs_n,
  output logic             ck_en,
  output logic             oe
);
  import hbx_pkg::*;

  hbx_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, cs_n_q, ck_en_q, oe_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_HDR;
        cnt_d   = '0;
      end
      ST_HDR: begin
        if (cnt_q == CNT_W'(HDR_BEATS - 1)) begin
          cnt_d   = '0;
          state_d = (rd_q && (DUMMY_CYC > 0)) ? ST_WAIT : ST_XFER;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (cnt_q == CNT_W'(DUMMY_CYC - 1)) begin
          cnt_d   = '0;
          state_d = ST_XFER;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_XFER: begin
        if (cnt_q == CNT_W'(last_idx)) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b1;
      cs_n_q  <= 1'b1;
      ck_en_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= (state_d == ST_IDLE);
      cs_n_q  <= (state_d == ST_IDLE);
      ck_en_q <= (state_d != ST_IDLE);
      oe_q    <= (state_d == ST_HDR) || ((state_d == ST_XFER) && !rd_q);
    end
  end

  assign accept   = (state_q == ST_IDLE) && start;
  assign shift_en = (state_q == ST_HDR) || ((state_q == ST_XFER) && !rd_q);
  assign cap_en   = (state_q == ST_XFER) && rd_q;
  assign cnt      = cnt_q;
  assign done     = done_q;
  assign cs_n     = cs_n_q;
  assign ck_en    = ck_en_q;
  assign oe       = oe_q;

  // R5
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) |-> (!oe_q && !cs_n_q));

  // R9
  busy_state_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |-> !done_q);
endmodule

// File: rtl/hbus_xact_engine.sv
module hbus_xact_engine #(
  parameter int ADDR_W    = 25,
  parameter int DUMMY_CYC = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              req_read,
  input  logic              req_reg_space,
  input  logic              req_linear,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              done,
  output logic [63:0]       rdata,
  output logic              bus_cs_n,
  output logic              bus_ck_en,
  output logic              bus_oe,
  output logic [15:0]       bus_dout,
  input  logic [15:0]       bus_din
);
  import hbx_pkg::*;

  localparam int DATA_W  = WORD_W * MAX_WORDS;
  localparam int SH_W    = HDR_W + DATA_W;
  localparam int CNT_MAX = (DUMMY_CYC > MAX_WORDS) ? DUMMY_CYC : MAX_WORDS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [HDR_W-1:0]  hdr_w;
  logic [DATA_W-1:0] wsw, wr_ord;
  logic [WORD_W-1:0] din_sw;
  logic [SH_W-1:0]   sh_q;
  logic              rd_q, reg_q;
  logic [1:0]        last_q;
  logic [DATA_W-1:0] rdata_q;
  logic              accept, shift_en, cap_en;
  logic [CNT_W-1:0]  cnt;

  hbx_ca_build #(.ADDR_W(ADDR_W)) u_ca (
    .rd        (req_read),
    .reg_space (req_reg_space),
    .linear    (req_linear),
    .byte_addr (req_addr),
    .hdr       (hdr_w)
  );

  hbx_swap #(.NW(MAX_WORDS)) u_wswap (
    .en   (req_reg_space),
    .din  (req_wdata),
    .dout (wsw)
  );

  hbx_swap #(.NW(1)) u_rswap (
    .en   (reg_q),
    .din  (bus_din),
    .dout (din_sw)
  );

  // word 0 ends up at the top of the data section, next to the header
  always_comb begin
    for (int i = 0; i < MAX_WORDS; i++) begin
      wr_ord[(MAX_WORDS-1-i)*WORD_W +: WORD_W] = wsw[i*WORD_W +: WORD_W];
    end
  end

  hbx_seq #(.DUMMY_CYC(DUMMY_CYC), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rd_q     (rd_q),
    .last_idx (last_q),
    .accept   (accept),
    .shift_en (shift_en),
    .cap_en   (cap_en),
    .cnt      (cnt),
    .done     (done),
    .cs_n     (bus_cs_n),
    .ck_en    (bus_ck_en),
    .oe       (bus_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      rd_q    <= 1'b0;
      reg_q   <= 1'b0;
      last_q  <= 2'd0;
      rdata_q <= '0;
    end else if (accept) begin
      sh_q    <= {hdr_w, wr_ord};
      rd_q    <= req_read;
      reg_q   <= req_reg_space;
      last_q  <= size_to_last(req_size);
      rdata_q <= '0;
    end else begin
      if (shift_en) begin
        sh_q <= {sh_q[SH_W-WORD_W-1:0], {WORD_W{1'b0}}};
      end
      if (cap_en) begin
        for (int k = 0; k < MAX_WORDS; k++) begin
          if (cnt == CNT_W'(k)) rdata_q[k*WORD_W +: WORD_W] <= din_sw;
        end
      end
    end
  end

  assign bus_dout = sh_q[SH_W-1 -: WORD_W];
  assign rdata    = rdata_q;

  // R9
  idle_cs_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> bus_cs_n);

  // R9
  ck_cs_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ck_en != bus_cs_n);

  // R5
  oe_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> !bus_cs_n);

  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(rd_q) && $stable(reg_q) && $stable(last_q)));
endmodule

// File: tb/tb_hbus_xact_engine.sv
`timescale 1ns/1ps
module tb_hbus_xact_engine;
  localparam int DUM = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        req_read = 1'b0, req_reg_space = 1'b0, req_linear = 1'b0;
  logic [24:0] req_addr = '0;
  logic [1:0]  req_size = 2'b00;
  logic [63:0] req_wdata = '0;
  logic        done;
  logic [63:0] rdata;
  logic        bus_cs_n, bus_ck_en, bus_oe;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hbus_xact_engine #(.ADDR_W(25), .DUMMY_CYC(DUM)) dut (
    .clk(clk), .rst(rst), .start(start), .req_read(req_read),
    .req_reg_space(req_reg_space), .req_linear(req_linear),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .bus_cs_n(bus_cs_n), .bus_ck_en(bus_ck_en),
    .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din)
  );

  typedef struct {
    bit          rd;
    logic [47:0] hdr;
    int          nw;
    logic [63:0] bw;
    logic [63:0] exp_rd;
  } item_t;

  item_t q[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sw16(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  function automatic item_t make_item(input bit rd, input bit sp, input bit lin,
      input logic [24:0] addr, input logic [1:0] sz, input logic [63:0] wd, input logic [63:0] dev);
    item_t it;
    logic [23:0] wa;
    wa = addr[24:1];
    it.rd = rd;
    it.hdr = {rd, sp, lin, 8'b0, wa[23:3], 13'b0, wa[2:0]};
    it.nw = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    it.bw = '0;
    it.exp_rd = '0;
    for (int i = 0; i < 4; i++) begin
      if (rd) begin
        it.bw[16*i +: 16] = dev[16*i +: 16];
        if (i < it.nw) it.exp_rd[16*i +: 16] = sp ? sw16(dev[16*i +: 16]) : dev[16*i +: 16];
      end else begin
        it.bw[16*i +: 16] = sp ? sw16(wd[16*i +: 16]) : wd[16*i +: 16];
      end
    end
    return it;
  endfunction

  task automatic set_req(input bit rd, input bit sp, input bit lin,
      input logic [24:0] addr, input logic [1:0] sz, input logic [63:0] wd);
    req_read = rd; req_reg_space = sp; req_linear = lin;
    req_addr = addr; req_size = sz; req_wdata = wd;
  endtask

  task automatic wait_done();
    while (done !== 1'b1) @(negedge clk);
  endtask

  // driver: pushes expectation, issues one request
  task automatic run(input bit rd, input bit sp, input bit lin, input logic [24:0] addr,
      input logic [1:0] sz, input logic [63:0] wd, input logic [63:0] dev, input bit poke_busy);
    q.push_back(make_item(rd, sp, lin, addr, sz, wd, dev));
    @(negedge clk);
    wait_done();
    set_req(rd, sp, lin, addr, sz, wd);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      // R11: strobes with altered fields while busy
      set_req(!rd, !sp, !lin, addr ^ 25'h0AAAAA, ~sz, ~wd);
      start = 1'b1;
      repeat (3) @(negedge clk);
      start = 1'b0;
    end
    wait_done();
  endtask

  // R10: start held high across two transactions
  task automatic run_back_to_back(input logic [24:0] addr, input logic [63:0] wd);
    q.push_back(make_item(1'b0, 1'b0, 1'b1, addr, 2'b01, wd, '0));
    q.push_back(make_item(1'b0, 1'b0, 1'b1, addr, 2'b01, wd, '0));
    @(negedge clk);
    wait_done();
    set_req(1'b0, 1'b0, 1'b1, addr, 2'b01, wd);
    start = 1'b1;
    @(negedge clk);
    wait_done();
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  // monitor and device model
  int gap = 1;
  initial begin
    forever begin
      @(negedge clk);
      if (bus_cs_n === 1'b0) begin
        item_t it;
        int    idx, len;
        chk(gap >= 1, "R10 chip-select gap", 64'(gap), 64'd1);
        if (q.size() == 0) begin
          chk(1'b0, "R11 unrequested transaction", 64'd1, 64'd0);
          while (bus_cs_n === 1'b0) @(negedge clk);
        end else begin
          it  = q.pop_front();
          idx = 0;
          len = 3 + (it.rd ? DUM : 0) + it.nw;
          while (bus_cs_n === 1'b0) begin
            chk(done === 1'b0, "R9 done low while busy", 64'(done), 64'd0);
            chk(bus_ck_en === 1'b1, "R9 clock enable", 64'(bus_ck_en), 64'd1);
            if (idx >= len) begin
              chk(1'b0, "R9 transaction too long", 64'(idx), 64'(len));
            end else if (idx < 3) begin
              chk(bus_oe === 1'b1 && bus_dout === it.hdr[16*(2-idx) +: 16],
                  "R2 R3 header beat", {47'b0, bus_oe, bus_dout}, {48'b1, it.hdr[16*(2-idx) +: 16]});
            end else if (it.rd && idx < 3 + DUM) begin
              chk(bus_oe === 1'b0, "R5 latency gap", 64'(bus_oe), 64'd0);
            end else if (it.rd) begin
              chk(bus_oe === 1'b0, "R8 read data phase", 64'(bus_oe), 64'd0);
              bus_din = it.bw[16*(idx-3-DUM) +: 16];
            end else begin
              chk(bus_oe === 1'b1 && bus_dout === it.bw[16*(idx-3) +: 16],
                  "R6 R7 write word", {47'b0, bus_oe, bus_dout}, {48'b1, it.bw[16*(idx-3) +: 16]});
            end
            idx++;
            @(negedge clk);
          end
          bus_din = '0;
          chk(idx == len, "R4 R5 R9 transaction length", 64'(idx), 64'(len));
          chk(done === 1'b1, "R9 done on completion", 64'(done), 64'd1);
          if (it.rd) chk(rdata === it.exp_rd, "R7 R8 read result", rdata, it.exp_rd);
        end
        gap = 1;
      end else begin
        gap++;
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 during reset
    chk(done === 1'b1 && bus_cs_n === 1'b1 && bus_ck_en === 1'b0 && bus_oe === 1'b0 && rdata === 64'd0,
        "R1 reset state", {59'b0, done, bus_cs_n, bus_ck_en, bus_oe, |rdata}, 64'b11000);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done === 1'b1 && bus_cs_n === 1'b1, "R1 after reset", {62'b0, done, bus_cs_n}, 64'b11);

    // memory write, one word, linear (R2 R3 R4 R6)
    run(1'b0, 1'b0, 1'b1, 25'h000100, 2'b00, 64'h0000_0000_0000_BEEF, '0, 1'b0);
    // register write, one word, byte swap (R7)
    run(1'b0, 1'b1, 1'b0, 25'h000AAA, 2'b00, 64'h0000_0000_0000_00AA, '0, 1'b0);
    // memory read, two words (R5 R8)
    run(1'b1, 1'b0, 1'b1, 25'h012346, 2'b01, '0, 64'h0000_0000_5678_1234, 1'b0);
    // register read, four words (R7 R8)
    run(1'b1, 1'b1, 1'b0, 25'h00004E, 2'b10, '0, 64'hA1B2_C3D4_E5F6_0718, 1'b0);
    // memory write, four words, top of address range (R3 R6)
    run(1'b0, 1'b0, 1'b0, 25'h1FFFFFE, 2'b10, 64'h4444_3333_2222_1111, '0, 1'b0);
    // size code 11 is four words (R4)
    run(1'b1, 1'b0, 1'b1, 25'h000010, 2'b11, '0, 64'hDEAD_BEEF_CAFE_F00D, 1'b0);
    // one-word read after a full read: upper words clear (R8)
    run(1'b1, 1'b0, 1'b1, 25'h0000F2, 2'b00, '0, 64'hFFFF_FFFF_FFFF_9ABC, 1'b0);
    // register write, two words (R7)
    run(1'b0, 1'b1, 1'b1, 25'h155554, 2'b01, 64'h0000_0000_0102_0304, '0, 1'b0);
    // strobes while busy are ignored (R11)
    run(1'b1, 1'b0, 1'b1, 25'h000200, 2'b01, '0, 64'h0000_0000_7777_8888, 1'b1);
    run(1'b0, 1'b1, 1'b0, 25'h000C00, 2'b10, 64'h0F0E_0D0C_0B0A_0908, '0, 1'b1);
    // back-to-back with held start (R10)
    run_back_to_back(25'h003000, 64'h0000_0000_AAAA_5555);

    repeat (8) @(negedge clk);
    chk(q.size() == 0, "R11 all expected transactions seen", 64'(q.size()), 64'd0);
    chk(bus_cs_n === 1'b1 && done === 1'b1, "R9 idle at end", {62'b0, bus_cs_n, done}, 64'b11);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule